// File: doc/BRIEF.md
# Windowed Deadman Supervisory Timer

This block is a supervisory timer on a simple single-cycle register port. Software sets the enable bit, and the timer then counts system clocks toward a programmed period. To keep the system alive, software must restart the count with two keys, written in order to two different registers. The first key arms the timer. The second key restarts the count, but it is accepted only while a clear window near the end of the period is open. If software writes nothing, writes a wrong key or writes the second key too early, the block reports it in a status register. An expired count or a premature second key raises a reset-request output and sets a sticky reset-cause flag.

Software reads the window-open status bit after arming and applies the second key once that bit reads 1. The period and the window length are plain cycle counts. The timeout in seconds is therefore the period divided by the clock rate. The error flags and the reset cause stay set until software writes a 1 to them. A write that clears the enable bit blocks the register port for the next cycle.

Top module: `dmt_deadman`

## Requirements
- R1: After reset the control, status, live-count and reset-cause registers read 0, the period register (0x60) and window register (0x70) read their default parameters, and both outputs are low.
- R2: Writing bit 15 of the control register (0x00) as 1 starts the live count (read at 0x40) at 0 the following cycle, and it rises by one every clock. Writing bit 15 as 0 stops the count and returns it to 0.
- R3: With period P, the count stops at P-1. P clock cycles after enable or restart, status bit 5 and rst_req_o assert, and the count stays frozen while bit 5 is set.
- R4: Status bit 0 (register 0x30) reads 1 while the timer is enabled, no event is pending and the count is at least P minus the window length W. Otherwise it reads 0.
- R5: A write to the arm register (0x10) whose bits 15:8 are not 0x40 sets status bit 7 and disarms the timer. A value of 0x40 arms it.
- R6: A write to the fire register (0x20) with bits 7:0 equal to 0x08, made while the timer is armed and the window is open, returns the count to 0 and disarms the timer. It sets no flag.
- R7: A fire write made while the window is open but with a wrong key, or with no prior arming, sets status bit 6. It does not restart the count and raises no event.
- R8: Any fire write made while the window is closed sets status bit 6 and status bit 5, and asserts rst_req_o, on the next clock edge.
- R9: Status bits 5, 6 and 7 stay set until a write of 1 to that bit at 0x30. rst_req_o follows bit 5.
- R10: An event sets bit 5 of the reset-cause register (0x50) and cause_o. These survive clearing the status and disabling the timer, and they clear only on a write of 1 to bit 5 at 0x50.
- R11: Arm and fire writes have no effect while the timer is disabled.
- R12: Any write in the cycle right after a write that turned the enable bit from 1 to 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the counted clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte offset of the register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid in the same cycle as a read; 0 otherwise |
| rst_req_o | output | 1 | Reset request, high while the event flag is set |
| cause_o | output | 1 | Sticky reset-cause flag |

## Verification
The bench reads the status register on the count values just below and exactly at the window threshold, and on the final counts before and after expiry. A threshold or terminal count that is off by one therefore shows up as a wrong status word in a known cycle. It sends a correct restart, a wrong second key inside the window, a second key before the window and a bad first key. A design that restarts on a wrong key would miss the later timeout. A design that ignores timing would not raise the early reset request. A design that merged the two error flags would show the wrong status bits. It also writes the period register in the cycle right after a disable, and sends keys while the timer is off. A design that lacked the blocking cycle or the enable gating would alter the period or flag errors.

// File: rtl/dmt_pkg.sv
package dmt_pkg;
    // register byte offsets
    localparam logic [7:0] OFS_CTRL  = 8'h00;
    localparam logic [7:0] OFS_ARM   = 8'h10;
    localparam logic [7:0] OFS_FIRE  = 8'h20;
    localparam logic [7:0] OFS_STAT  = 8'h30;
    localparam logic [7:0] OFS_CNT   = 8'h40;
    localparam logic [7:0] OFS_CAUSE = 8'h50;
    localparam logic [7:0] OFS_PER   = 8'h60;
    localparam logic [7:0] OFS_WIN   = 8'h70;

    // key values
    localparam logic [7:0] KEY_ARM  = 8'h40;
    localparam logic [7:0] KEY_FIRE = 8'h08;

    // bit positions
    localparam int B_EN    = 15;
    localparam int B_WIN   = 0;
    localparam int B_EVT   = 5;
    localparam int B_BAD2  = 6;
    localparam int B_BAD1  = 7;
    localparam int B_CAUSE = 5;
endpackage

// File: rtl/dmt_count.sv
module dmt_count #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          hold,
    input  logic          restart,
    input  logic [CW-1:0] limit,
    input  logic [CW-1:0] win_len,
    output logic [CW-1:0] count,
    output logic          win_open,
    output logic          expire
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_t;

    cnt_t q, d;
    logic [CW-1:0] thresh_w;

    always_comb begin
        thresh_w = (win_len >= limit) ? '0 : limit - win_len;
        expire   = en & ~hold & ((limit == '0) | (q.cnt >= limit - CW'(1)));
        win_open = en & ~hold & (q.cnt >= thresh_w);
        d = q;
        if (!en || restart) begin
            d.cnt = '0;
        end else if (!hold && !expire) begin
            d.cnt = q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign count = q.cnt;
endmodule

// File: rtl/dmt_keys.sv
module dmt_keys
    import dmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       arm_wr,
    input  logic [7:0] arm_key,
    input  logic       fire_wr,
    input  logic [7:0] fire_key,
    input  logic       win_open,
    output logic       restart,
    output logic       bad1,
    output logic       bad2,
    output logic       late
);
    typedef struct packed {
        logic armed;
    } key_t;

    key_t q, d;

    always_comb begin
        restart = en & fire_wr & q.armed & win_open & (fire_key == KEY_FIRE);
        late    = en & fire_wr & ~win_open;
        bad2    = en & fire_wr & ~restart;
        bad1    = en & arm_wr & (arm_key != KEY_ARM);
        d = q;
        if (!en)          d.armed = 1'b0;
        else if (arm_wr)  d.armed = (arm_key == KEY_ARM);
        else if (fire_wr) d.armed = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/dmt_deadman.sv
module dmt_deadman
    import dmt_pkg::*;
#(
    parameter int AW         = 8,
    parameter int DW         = 32,
    parameter int CW         = 32,
    parameter int DEF_PERIOD = 1000,
    parameter int DEF_WINDOW = 100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          rst_req_o,
    output logic          cause_o
);
    typedef struct packed {
        logic          en;
        logic          blank;
        logic          evt;
        logic          bad1;
        logic          bad2;
        logic          cause;
        logic [CW-1:0] period;
        logic [CW-1:0] window;
    } regs_t;

    regs_t q, d;

    logic          wr_ok, arm_wr, fire_wr;
    logic [CW-1:0] cnt_w;
    logic          win_w, expire_w, restart_w, bad1_w, bad2_w, late_w;

    assign wr_ok   = bus_sel & bus_we & ~q.blank;
    assign arm_wr  = wr_ok & (bus_addr == AW'(OFS_ARM));
    assign fire_wr = wr_ok & (bus_addr == AW'(OFS_FIRE));

    dmt_count #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (q.en),
        .hold     (q.evt),
        .restart  (restart_w),
        .limit    (q.period),
        .win_len  (q.window),
        .count    (cnt_w),
        .win_open (win_w),
        .expire   (expire_w)
    );

    dmt_keys u_keys (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (q.en),
        .arm_wr   (arm_wr),
        .arm_key  (bus_wdata[15:8]),
        .fire_wr  (fire_wr),
        .fire_key (bus_wdata[7:0]),
        .win_open (win_w),
        .restart  (restart_w),
        .bad1     (bad1_w),
        .bad2     (bad2_w),
        .late     (late_w)
    );

    always_comb begin
        d = q;
        d.blank = 1'b0;
        if (wr_ok && bus_addr == AW'(OFS_CTRL)) begin
            d.en    = bus_wdata[B_EN];
            d.blank = q.en & ~bus_wdata[B_EN];
        end
        if (wr_ok && bus_addr == AW'(OFS_PER)) d.period = bus_wdata[CW-1:0];
        if (wr_ok && bus_addr == AW'(OFS_WIN)) d.window = bus_wdata[CW-1:0];
        if (wr_ok && bus_addr == AW'(OFS_STAT)) begin
            if (bus_wdata[B_EVT])  d.evt  = 1'b0;
            if (bus_wdata[B_BAD2]) d.bad2 = 1'b0;
            if (bus_wdata[B_BAD1]) d.bad1 = 1'b0;
        end
        if (wr_ok && bus_addr == AW'(OFS_CAUSE) && bus_wdata[B_CAUSE]) d.cause = 1'b0;
        // new events win over a clear in the same cycle
        if ((expire_w & ~restart_w) | late_w) begin
            d.evt   = 1'b1;
            d.cause = 1'b1;
        end
        if (bad1_w) d.bad1 = 1'b1;
        if (bad2_w) d.bad2 = 1'b1;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_we) begin
            case (bus_addr)
                AW'(OFS_CTRL):  bus_rdata[B_EN] = q.en;
                AW'(OFS_STAT): begin
                    bus_rdata[B_WIN]  = win_w;
                    bus_rdata[B_EVT]  = q.evt;
                    bus_rdata[B_BAD2] = q.bad2;
                    bus_rdata[B_BAD1] = q.bad1;
                end
                AW'(OFS_CNT):   bus_rdata = DW'(cnt_w);
                AW'(OFS_CAUSE): bus_rdata[B_CAUSE] = q.cause;
                AW'(OFS_PER):   bus_rdata = DW'(q.period);
                AW'(OFS_WIN):   bus_rdata = DW'(q.window);
                default:        bus_rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.period <= CW'(DEF_PERIOD);
            q.window <= CW'(DEF_WINDOW);
        end else begin
            q <= d;
        end
    end

    assign rst_req_o = q.evt;
    assign cause_o   = q.cause;
endmodule

// File: rtl/dmt_deadman_chk.sv
module dmt_deadman_chk
    import dmt_pkg::*;
#(
    parameter int AW = 8,
    parameter int CW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_sel,
    input logic          bus_we,
    input logic [AW-1:0] bus_addr,
    input logic          evt_bit,
    input logic          rst_req_o,
    input logic          cause_o,
    input logic          en_q,
    input logic          blank_q,
    input logic          restart,
    input logic          win_open,
    input logic [CW-1:0] count,
    input logic [CW-1:0] period
);
    logic evt_clr_wr, per_wr;
    assign evt_clr_wr = bus_sel & bus_we & (bus_addr == AW'(OFS_STAT)) & evt_bit;
    assign per_wr     = bus_sel & bus_we & (bus_addr == AW'(OFS_PER));

    a_r9_evt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req_o && !evt_clr_wr) |=> rst_req_o);

    a_r10_cause_on_evt: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req_o) |-> cause_o);

    a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> (count == '0));

    a_r6_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (count == '0));

    a_r4_closed_on_evt: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> !win_open);

    a_r12_blank_write: assert property (@(posedge clk) disable iff (!rst_n)
        (blank_q && per_wr) |=> $stable(period));
endmodule

bind dmt_deadman dmt_deadman_chk #(.AW(AW), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .evt_bit   (bus_wdata[dmt_pkg::B_EVT]),
    .rst_req_o (rst_req_o),
    .cause_o   (cause_o),
    .en_q      (q.en),
    .blank_q   (q.blank),
    .restart   (restart_w),
    .win_open  (win_w),
    .count     (cnt_w),
    .period    (q.period)
);

// File: tb/sim_dmt_deadman.sv
module sim_dmt_deadman;
    localparam int CLK_PER = 10;
    localparam int P0 = 20;
    localparam int W0 = 5;

    localparam logic [7:0] A_CTRL  = 8'h00;
    localparam logic [7:0] A_ARM   = 8'h10;
    localparam logic [7:0] A_FIRE  = 8'h20;
    localparam logic [7:0] A_STAT  = 8'h30;
    localparam logic [7:0] A_CNT   = 8'h40;
    localparam logic [7:0] A_CAUSE = 8'h50;
    localparam logic [7:0] A_PER   = 8'h60;
    localparam logic [7:0] A_WIN   = 8'h70;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rst_req_o, cause_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PER/2) clk = ~clk;

    dmt_deadman #(.DEF_PERIOD(P0), .DEF_WINDOW(W0)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .rst_req_o (rst_req_o),
        .cause_o   (cause_o)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // driver tasks: one access per cycle, driven at the falling edge
    task automatic wr(logic [7:0] a, logic [31:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = v;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, logic [31:0] v, string tag);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        exp_q.push_back(v);
        tag_q.push_back(tag);
        @(posedge clk); #1;
        bus_sel = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: compares each read against the scoreboard
    always @(negedge clk) begin
        #(CLK_PER/4);
        if (bus_sel && !bus_we) begin
            if (exp_q.size() == 0) begin
                check("scoreboard underflow", 32'h1, 32'h0);
            end else begin
                check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        #(CLK_PER * 50000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_CTRL, 32'h0, "R1 ctrl");
        rd(A_STAT, 32'h0, "R1 status");
        rd(A_CNT, 32'h0, "R1 count");
        rd(A_PER, P0, "R1 period");
        rd(A_WIN, W0, "R1 window");
        rd(A_CAUSE, 32'h0, "R1 cause reg");
        check("R1 rst_req", rst_req_o, 1'b0);
        check("R1 cause_o", cause_o, 1'b0);

        // R11 keys while disabled
        wr(A_ARM, 32'h1200);
        wr(A_FIRE, 32'h08);
        rd(A_STAT, 32'h0, "R11 status");
        check("R11 rst_req", rst_req_o, 1'b0);

        // R2 counting
        wr(A_CTRL, 32'h8000);
        rd(A_CNT, 32'd0, "R2 count start");
        rd(A_CTRL, 32'h8000, "R2 ctrl");
        rd(A_CNT, 32'd2, "R2 count step");
        rd(A_STAT, 32'h0, "R4 early closed");

        // R3 timeout
        idle(30);
        rd(A_STAT, 32'h20, "R3 event");
        rd(A_CNT, P0 - 1, "R3 frozen count");
        check("R3 rst_req", rst_req_o, 1'b1);
        check("R10 cause_o", cause_o, 1'b1);
        rd(A_CAUSE, 32'h20, "R10 cause reg");

        // R12 write after disable is dropped
        wr(A_CTRL, 32'h0);
        wr(A_PER, 32'd33);
        rd(A_PER, P0, "R12 period kept");
        rd(A_CNT, 32'd0, "R2 stop");

        // R9 and R10 clearing
        wr(A_STAT, 32'h20);
        rd(A_STAT, 32'h0, "R9 w1c event");
        check("R9 rst_req", rst_req_o, 1'b0);
        check("R10 cause sticky", cause_o, 1'b1);
        wr(A_CAUSE, 32'h20);
        rd(A_CAUSE, 32'h0, "R10 cause clear");
        check("R10 cause_o clear", cause_o, 1'b0);

        // R6 good restart, R4 threshold
        wr(A_CTRL, 32'h8000);
        wr(A_ARM, 32'h4000);
        idle(13);
        rd(A_STAT, 32'h0, "R4 count P-W-1");
        rd(A_STAT, 32'h1, "R4 count P-W");
        wr(A_FIRE, 32'h08);
        rd(A_STAT, 32'h0, "R6 status");
        rd(A_CNT, 32'd1, "R6 count");
        idle(3);
        rd(A_STAT, 32'h0, "R6 no timeout");

        // R5 bad first key
        wr(A_ARM, 32'h1200);
        rd(A_STAT, 32'h80, "R5 bad1");
        wr(A_STAT, 32'h80);
        rd(A_STAT, 32'h0, "R9 w1c bad1");

        // R8 fire while window closed
        wr(A_FIRE, 32'h08);
        check("R8 rst_req", rst_req_o, 1'b1);
        rd(A_STAT, 32'h60, "R8 status");
        wr(A_CTRL, 32'h0);
        idle(1);
        wr(A_STAT, 32'h60);
        wr(A_CAUSE, 32'h20);
        rd(A_STAT, 32'h0, "R9 clear all");

        // R7 wrong second key in window
        wr(A_CTRL, 32'h8000);
        wr(A_ARM, 32'h4000);
        idle(14);
        rd(A_STAT, 32'h1, "R4 open");
        wr(A_FIRE, 32'h09);
        check("R7 no event", rst_req_o, 1'b0);
        rd(A_STAT, 32'h41, "R7 bad2");
        idle(2);
        rd(A_STAT, 32'h60, "R7 no restart");
        wr(A_CTRL, 32'h0);
        idle(1);
        wr(A_STAT, 32'hE0);
        wr(A_CAUSE, 32'h20);
        rd(A_STAT, 32'h0, "R9 clear again");

        // R3 and R4 with a reprogrammed period
        wr(A_PER, 32'd8);
        wr(A_WIN, 32'd3);
        wr(A_CTRL, 32'h8000);
        idle(5);
        rd(A_STAT, 32'h1, "R4 open at P-W");
        rd(A_STAT, 32'h1, "R4 open");
        rd(A_STAT, 32'h1, "R3 last count");
        rd(A_STAT, 32'h20, "R3 expiry P=8");
        rd(A_CNT, 32'd7, "R3 frozen P=8");

        idle(2);
        check("scoreboard drained", exp_q.size(), 32'd0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule